// File: doc/BRIEF.md
# SCAM Selection and Transfer Engine

This block carries out the bus side of automatic SCSI address configuration (SCAM). On a select command it waits for the bus to go free and then arbitrates. A master arbitrates with its own ID on the data bus; a slave arbitrates with no ID. If it loses, it drops every line and tries again at the next bus free. If it wins, it holds a selection window whose length in milliseconds comes from a timeout input. At the end of the window it samples C/D. An asserted C/D means a master answered, and the engine stays connected as a SCAM device. Otherwise it returns to the disconnected state.

While connected, each transfer command first checks that C/D is still held. If it is, the engine drives the five low data bits from `tx_data` for a fixed number of cycles. On the last of those cycles it latches the five low bits it sees on the bus. If C/D has been dropped, it releases the bus and reports a lost link. A command that does not fit the current state raises an invalid-command code and has no other effect.

The states are IDLE (disconnected), WAIT_FREE (waiting for bus free), ARB (arbitrating), SEL_WIN (selection window), LINKED (connected as a SCAM device) and CYCLE (transfer cycle). The transitions are:
- IDLE→WAIT_FREE on select.
- WAIT_FREE→ARB on bus free.
- ARB→WAIT_FREE on a loss, or ARB→SEL_WIN on a win.
- SEL_WIN→LINKED with C/D, or SEL_WIN→IDLE without it.
- LINKED→CYCLE on a transfer with C/D, or LINKED→IDLE on a transfer without C/D.
- CYCLE→LINKED when the cycle ends.

Top module: `scam_engine`

## Requirements
- R1: While `rst_n` is low, `link_state` is 0 and `irq`, `irq_code`, `rx_data`, `bsy_drv`, `sel_drv` and `data_drv` are all zero.
- R2: After a select command the engine asserts nothing until `bus_bsy_in` and `bus_sel_in` are both low in the same cycle. It then drives `bsy_drv` for exactly ARB_CYC cycles of arbitration.
- R3: During arbitration a master (role bit 0) drives only data bit `own_id`. A slave (role bit 1) drives no data bit.
- R4: At the end of arbitration, the engine loses if `bus_sel_in` is high. A master also loses if any data bit above `own_id` is set on `bus_data_in`; a slave also loses if any data bit at all is set. A loser releases all lines, reports nothing, and waits for the next bus free.
- R5: A win drives `sel_drv` and `bsy_drv` for tmo_period*CLK_PER_MS+1 cycles. `tmo_period` is sampled when arbitration ends.
- R6: When the selection window ends with `bus_cd_in` high, the engine reports code 12h and `link_state` becomes 2 (linked). With `bus_cd_in` low it reports code 17h, `link_state` becomes 0 and all lines are released.
- R7: A transfer command in the linked state with `bus_cd_in` high drives `tx_data` (captured at the command) on data bits 4:0 for XFER_CYC cycles. On the last of those cycles it latches `bus_data_in[4:0]` into `rx_data`, reports code 1Ch and returns to linked.
- R8: A transfer command in the linked state with `bus_cd_in` low reports code 1Dh, drives no data and returns to `link_state` 0 with all lines released.
- R9: The following commands report code 40h and change nothing else: a transfer while disconnected, a select while linked, and any command in WAIT_FREE, ARB, SEL_WIN or CYCLE. If an invalid command and a state event happen in the same cycle, the event's code wins.
- R10: `irq` is a one-cycle pulse. `irq_code` changes only together with a pulse and holds its value between pulses.
- R11: The role bit is captured when the select command is accepted. Later changes to it do not affect that selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sel | input | 1 | Start-selection command pulse |
| cmd_xfer | input | 1 | SCAM transfer command pulse |
| role_slave | input | 1 | 1 = slave (no ID), 0 = master (with ID) |
| own_id | input | ID_W | This device's bus ID |
| tmo_period | input | TMO_W | Selection window length in milliseconds |
| tx_data | input | 5 | Outgoing SCAM bits |
| bus_bsy_in | input | 1 | BSY as driven by other devices |
| bus_sel_in | input | 1 | SEL as driven by other devices |
| bus_cd_in | input | 1 | C/D line from the bus |
| bus_data_in | input | 2**ID_W | Data bus as driven by other devices |
| bsy_drv | output | 1 | Drive BSY |
| sel_drv | output | 1 | Drive SEL |
| data_drv | output | 2**ID_W | Data bits to assert |
| rx_data | output | 5 | Latched incoming SCAM bits |
| link_state | output | 2 | 0 disconnected, 1 selecting, 2 linked |
| irq | output | 1 | Interrupt pulse |
| irq_code | output | 8 | Code of the latest interrupt |

## Verification
The bench builds the engine with a four-cycle millisecond, three arbitration cycles and two transfer cycles. With these values, windows of zero, one and two milliseconds end within a few dozen clocks, so both selection outcomes can be compared cycle by cycle against the model. The short arbitration window lets the bench run repeated loss-and-retry loops within the run: for a master against a higher ID, and for a slave against any ID. During those loops the bench flips the role input to show that the role is captured at the command.

// File: rtl/scam_pkg.sv
package scam_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_FREE,
        ST_ARB,
        ST_SEL_WIN,
        ST_LINKED,
        ST_CYCLE
    } scam_st_e;

    localparam logic [7:0] IRQ_LINKED    = 8'h12;
    localparam logic [7:0] IRQ_NO_MASTER = 8'h17;
    localparam logic [7:0] IRQ_CYCLE_OK  = 8'h1C;
    localparam logic [7:0] IRQ_CD_LOST   = 8'h1D;
    localparam logic [7:0] IRQ_BAD_CMD   = 8'h40;

    localparam logic [1:0] LINK_FREE = 2'd0;
    localparam logic [1:0] LINK_SEEK = 2'd1;
    localparam logic [1:0] LINK_CONN = 2'd2;

    localparam int SCAM_W = 5;
endpackage

// File: rtl/scam_ms_timer.sv
module scam_ms_timer #(
    parameter int CLK_PER_MS = 20000,
    parameter int TMO_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] period,
    output logic             done
);
    localparam int PRE_W = $clog2(CLK_PER_MS + 1);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [TMO_W-1:0] ms_left_q;
    logic             run_q;

    assign done = run_q && (ms_left_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q     <= '0;
            ms_left_q <= '0;
            run_q     <= 1'b0;
        end else if (start) begin
            pre_q     <= '0;
            ms_left_q <= period;
            run_q     <= 1'b1;
        end else if (done) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            if (pre_q == PRE_LAST) begin
                pre_q     <= '0;
                ms_left_q <= ms_left_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scam_arb_judge.sv
module scam_arb_judge #(
    parameter int ID_W = 3
) (
    input  logic              slave,
    input  logic [ID_W-1:0]   own_id,
    input  logic              bus_sel,
    input  logic [2**ID_W-1:0] bus_data,
    output logic              lose
);
    localparam int DATA_W = 2 ** ID_W;

    logic [DATA_W-1:0] above;

    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_above
            assign above[g] = (int'(own_id) < g);
        end
    endgenerate

    logic rival_hi;
    logic rival_any;

    assign rival_hi  = |(bus_data & above);
    assign rival_any = |bus_data;
    assign lose      = bus_sel || (slave ? rival_any : rival_hi);
endmodule

// File: rtl/scam_xfer_path.sv
module scam_xfer_path #(
    parameter int XFER_CYC = 20,
    parameter int DATA_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       launch,
    input  logic [scam_pkg::SCAM_W-1:0] tx_in,
    input  logic [DATA_W-1:0]          bus_in,
    output logic [scam_pkg::SCAM_W-1:0] tx_hold,
    output logic                       last,
    output logic [scam_pkg::SCAM_W-1:0] rx_out
);
    localparam int CNT_W = $clog2(XFER_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(XFER_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;

    assign last = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            tx_hold <= '0;
            rx_out  <= '0;
        end else if (launch) begin
            cnt_q   <= CNT_LAST;
            busy_q  <= 1'b1;
            tx_hold <= tx_in;
        end else if (last) begin
            busy_q <= 1'b0;
            rx_out <= bus_in[scam_pkg::SCAM_W-1:0];
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/scam_engine.sv
module scam_engine #(
    parameter int CLK_PER_MS = 20000,
    parameter int TMO_W      = 8,
    parameter int ID_W       = 3,
    parameter int ARB_CYC    = 48,
    parameter int XFER_CYC   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_sel,
    input  logic                cmd_xfer,
    input  logic                role_slave,
    input  logic [ID_W-1:0]     own_id,
    input  logic [TMO_W-1:0]    tmo_period,
    input  logic [4:0]          tx_data,
    input  logic                bus_bsy_in,
    input  logic                bus_sel_in,
    input  logic                bus_cd_in,
    input  logic [2**ID_W-1:0]  bus_data_in,
    output logic                bsy_drv,
    output logic                sel_drv,
    output logic [2**ID_W-1:0]  data_drv,
    output logic [4:0]          rx_data,
    output logic [1:0]          link_state,
    output logic                irq,
    output logic [7:0]          irq_code
);
    import scam_pkg::*;

    localparam int DATA_W = 2 ** ID_W;
    localparam int ARB_W  = $clog2(ARB_CYC + 1);
    localparam logic [ARB_W-1:0] ARB_LAST = ARB_W'(ARB_CYC - 1);

    scam_st_e st_q, st_nx;
    logic [ARB_W-1:0] arb_cnt_q;
    logic             slave_q;

    logic       ev_fire;
    logic [7:0] ev_code;
    logic       arb_load, tmr_start, xfer_launch, role_take;
    logic       tmr_done, arb_lose, xfer_last, cmd_any, bus_free;
    logic [SCAM_W-1:0] tx_hold;

    assign cmd_any  = cmd_sel || cmd_xfer;
    assign bus_free = !bus_bsy_in && !bus_sel_in;

    scam_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(tmr_start),
        .period(tmo_period), .done(tmr_done)
    );

    scam_arb_judge #(.ID_W(ID_W)) u_judge (
        .slave(slave_q), .own_id(own_id), .bus_sel(bus_sel_in),
        .bus_data(bus_data_in), .lose(arb_lose)
    );

    scam_xfer_path #(.XFER_CYC(XFER_CYC), .DATA_W(DATA_W)) u_xfer (
        .clk(clk), .rst_n(rst_n), .launch(xfer_launch), .tx_in(tx_data),
        .bus_in(bus_data_in), .tx_hold(tx_hold), .last(xfer_last),
        .rx_out(rx_data)
    );

    // next-state and event selection
    always_comb begin
        st_nx       = st_q;
        ev_fire     = 1'b0;
        ev_code     = irq_code;
        arb_load    = 1'b0;
        tmr_start   = 1'b0;
        xfer_launch = 1'b0;
        role_take   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_sel) begin
                    st_nx     = ST_WAIT_FREE;
                    role_take = 1'b1;
                end else if (cmd_xfer) begin
                    ev_fire = 1'b1;
                    ev_code = IRQ_BAD_CMD;
                end
            end
            ST_WAIT_FREE: begin
                if (cmd_any) begin
                    ev_fire = 1'b1;
                    ev_code = IRQ_BAD_CMD;
                end
                if (bus_free) begin
                    st_nx    = ST_ARB;
                    arb_load = 1'b1;
                end
            end
            ST_ARB: begin
                if (cmd_any) begin
                    ev_fire = 1'b1;
                    ev_code = IRQ_BAD_CMD;
                end
                if (arb_cnt_q == '0) begin
                    if (arb_lose) begin
                        st_nx = ST_WAIT_FREE;
                    end else begin
                        st_nx     = ST_SEL_WIN;
                        tmr_start = 1'b1;
                    end
                end
            end
            ST_SEL_WIN: begin
                if (cmd_any) begin
                    ev_fire = 1'b1;
                    ev_code = IRQ_BAD_CMD;
                end
                if (tmr_done) begin
                    ev_fire = 1'b1;
                    if (bus_cd_in) begin
                        st_nx   = ST_LINKED;
                        ev_code = IRQ_LINKED;
                    end else begin
                        st_nx   = ST_IDLE;
                        ev_code = IRQ_NO_MASTER;
                    end
                end
            end
            ST_LINKED: begin
                if (cmd_sel) begin
                    ev_fire = 1'b1;
                    ev_code = IRQ_BAD_CMD;
                end else if (cmd_xfer) begin
                    if (bus_cd_in) begin
                        st_nx       = ST_CYCLE;
                        xfer_launch = 1'b1;
                    end else begin
                        st_nx   = ST_IDLE;
                        ev_fire = 1'b1;
                        ev_code = IRQ_CD_LOST;
                    end
                end
            end
            ST_CYCLE: begin
                if (cmd_any) begin
                    ev_fire = 1'b1;
                    ev_code = IRQ_BAD_CMD;
                end
                if (xfer_last) begin
                    st_nx   = ST_LINKED;
                    ev_fire = 1'b1;
                    ev_code = IRQ_CYCLE_OK;
                end
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            arb_cnt_q <= '0;
            slave_q   <= 1'b0;
            irq       <= 1'b0;
            irq_code  <= '0;
        end else begin
            st_q <= st_nx;
            irq  <= ev_fire;
            if (ev_fire) irq_code <= ev_code;
            if (role_take) slave_q <= role_slave;
            if (arb_load) arb_cnt_q <= ARB_LAST;
            else if (st_q == ST_ARB && arb_cnt_q != '0) arb_cnt_q <= arb_cnt_q - 1'b1;
        end
    end

    // line drives and state indication
    always_comb begin
        bsy_drv    = 1'b0;
        sel_drv    = 1'b0;
        data_drv   = '0;
        link_state = LINK_FREE;
        unique case (st_q)
            ST_IDLE: link_state = LINK_FREE;
            ST_WAIT_FREE: link_state = LINK_SEEK;
            ST_ARB: begin
                link_state = LINK_SEEK;
                bsy_drv    = 1'b1;
                if (!slave_q) data_drv = DATA_W'(1) << own_id;
            end
            ST_SEL_WIN: begin
                link_state = LINK_SEEK;
                bsy_drv    = 1'b1;
                sel_drv    = 1'b1;
            end
            ST_LINKED: begin
                link_state = LINK_CONN;
                sel_drv    = 1'b1;
            end
            ST_CYCLE: begin
                link_state = LINK_CONN;
                sel_drv    = 1'b1;
                data_drv   = {{(DATA_W-SCAM_W){1'b0}}, tx_hold};
            end
            default: link_state = LINK_FREE;
        endcase
    end
endmodule

// File: rtl/scam_engine_chk.sv
module scam_engine_chk #(
    parameter int ID_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_bsy_in,
    input logic               bus_sel_in,
    input logic               bsy_drv,
    input logic               sel_drv,
    input logic [2**ID_W-1:0] data_drv,
    input logic [4:0]         rx_data,
    input logic [1:0]         link_state,
    input logic               irq,
    input logic [7:0]         irq_code
);
    // R2: arbitration begins only after a bus-free cycle
    p_free_before_arb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bsy_drv) && !sel_drv) |-> $past(!bus_bsy_in && !bus_sel_in));

    // R3: at most one ID bit during arbitration
    p_one_id_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bsy_drv && !sel_drv) |-> $onehot0(data_drv));

    // R6: linked code comes with linked state
    p_linked_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_code == 8'h12) |-> (link_state == 2'd2));

    // R8: lost link releases everything
    p_cd_lost_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_code == 8'h1D) |-> (!bsy_drv && !sel_drv && data_drv == '0 && link_state == 2'd0));

    // R9: invalid command leaves the state indication alone
    p_bad_cmd_noop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_code == 8'h40) |-> $stable(link_state));

    // R10: code only moves with a pulse
    p_code_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(irq_code));

    // R7: received bits only move on a completed cycle
    p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq && irq_code == 8'h1C) |-> $stable(rx_data));
endmodule

bind scam_engine scam_engine_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_bsy_in(bus_bsy_in), .bus_sel_in(bus_sel_in),
    .bsy_drv(bsy_drv), .sel_drv(sel_drv), .data_drv(data_drv), .rx_data(rx_data),
    .link_state(link_state), .irq(irq), .irq_code(irq_code)
);

// File: tb/sim_scam_engine.sv
module sim_scam_engine;
    localparam int CPM = 4;
    localparam int ARB = 3;
    localparam int XF  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_sel = 1'b0, cmd_xfer = 1'b0, role_slave = 1'b0;
    logic [2:0] own_id = 3'd4;
    logic [7:0] tmo_period = 8'd2;
    logic [4:0] tx_data = 5'd0;
    logic bus_bsy_in = 1'b0, bus_sel_in = 1'b0, bus_cd_in = 1'b0;
    logic [7:0] bus_data_in = 8'd0;
    logic bsy_drv, sel_drv, irq;
    logic [7:0] data_drv, irq_code;
    logic [4:0] rx_data;
    logic [1:0] link_state;

    always #10 clk = ~clk;

    scam_engine #(.CLK_PER_MS(CPM), .TMO_W(8), .ID_W(3), .ARB_CYC(ARB), .XFER_CYC(XF)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .cmd_xfer(cmd_xfer),
        .role_slave(role_slave), .own_id(own_id), .tmo_period(tmo_period),
        .tx_data(tx_data), .bus_bsy_in(bus_bsy_in), .bus_sel_in(bus_sel_in),
        .bus_cd_in(bus_cd_in), .bus_data_in(bus_data_in), .bsy_drv(bsy_drv),
        .sel_drv(sel_drv), .data_drv(data_drv), .rx_data(rx_data),
        .link_state(link_state), .irq(irq), .irq_code(irq_code)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit started = 0;

    // behavioural reference: 0 idle,1 wait,2 arb,3 window,4 linked,5 cycle
    int m_st = 0, m_cnt = 0, m_code = 0, m_rx = 0, m_tx = 0;
    bit m_slave = 0, m_irq = 0;

    function automatic bit lost_now();
        if (bus_sel_in) return 1;
        if (m_slave) return bus_data_in != 0;
        return (int'(bus_data_in) >> (int'(own_id) + 1)) != 0;
    endfunction

    task automatic note(input int c);
        m_irq = 1;
        m_code = c;
    endtask

    always @(posedge clk) begin
        started = 1;
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_code = 0; m_rx = 0; m_tx = 0; m_slave = 0; m_irq = 0;
        end else begin
            m_irq = 0;
            case (m_st)
                0: if (cmd_sel) begin m_st = 1; m_slave = role_slave; end
                   else if (cmd_xfer) note('h40);
                1: begin
                    if (cmd_sel || cmd_xfer) note('h40);
                    if (!bus_bsy_in && !bus_sel_in) begin m_st = 2; m_cnt = ARB; end
                end
                2: begin
                    if (cmd_sel || cmd_xfer) note('h40);
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (lost_now()) m_st = 1;
                        else begin m_st = 3; m_cnt = int'(tmo_period) * CPM + 1; end
                    end
                end
                3: begin
                    if (cmd_sel || cmd_xfer) note('h40);
                    m_cnt--;
                    if (m_cnt == 0) begin
                        if (bus_cd_in) begin m_st = 4; note('h12); end
                        else begin m_st = 0; note('h17); end
                    end
                end
                4: if (cmd_sel) note('h40);
                   else if (cmd_xfer) begin
                       if (bus_cd_in) begin m_st = 5; m_cnt = XF; m_tx = int'(tx_data); end
                       else begin m_st = 0; note('h1D); end
                   end
                5: begin
                    if (cmd_sel || cmd_xfer) note('h40);
                    m_cnt--;
                    if (m_cnt == 0) begin m_rx = int'(bus_data_in[4:0]); m_st = 4; note('h1C); end
                end
                default: m_st = 0;
            endcase
        end
    end

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            int e_data;
            e_data = (m_st == 2 && !m_slave) ? (1 << int'(own_id)) : (m_st == 5 ? m_tx : 0);
            cmp("R2", "bsy_drv", int'(bsy_drv), int'(m_st == 2 || m_st == 3));
            cmp("R5", "sel_drv", int'(sel_drv), int'(m_st >= 3));
            cmp("R3", "data_drv", int'(data_drv), e_data);
            cmp("R6", "link_state", int'(link_state), m_st == 0 ? 0 : (m_st <= 3 ? 1 : 2));
            cmp("R10", "irq", int'(irq), int'(m_irq));
            cmp("R9", "irq_code", int'(irq_code), m_code);
            cmp("R7", "rx_data", int'(rx_data), m_rx);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    task automatic pulse_sel();
        @(posedge clk); #3 cmd_sel = 1'b1;
        @(posedge clk); #3 cmd_sel = 1'b0;
    endtask

    task automatic pulse_xfer();
        @(posedge clk); #3 cmd_xfer = 1'b1;
        @(posedge clk); #3 cmd_xfer = 1'b0;
    endtask

    task automatic expect_named(input string tag, input string what, input int act, input int exp);
        @(negedge clk);
        cmp(tag, what, act, exp);
    endtask

    initial begin
        step(3);
        @(negedge clk);
        cmp("R1", "reset link", int'(link_state), 0);
        cmp("R1", "reset drives", int'({bsy_drv, sel_drv, data_drv}), 0);
        cmp("R1", "reset irq/code/rx", int'({irq, irq_code, rx_data}), 0);
        step(1);
        rst_n = 1'b1;
        step(2);

        // R9: transfer while disconnected
        pulse_xfer();
        step(1);
        cmp("R9", "bad xfer code", int'(irq_code), 'h40);
        cmp("R9", "bad xfer link", int'(link_state), 0);

        // R2: busy bus holds off arbitration
        bus_bsy_in = 1'b1; tmo_period = 8'd2;
        pulse_sel();
        step(5);
        cmp("R2", "held off bsy", int'(bsy_drv), 0);
        cmp("R2", "held off link", int'(link_state), 1);
        bus_bsy_in = 1'b0; bus_cd_in = 1'b1;
        step(16);
        cmp("R6", "linked code", int'(irq_code), 'h12);
        cmp("R6", "linked state", int'(link_state), 2);

        // R9: select while linked
        pulse_sel();
        step(1);
        cmp("R9", "bad sel code", int'(irq_code), 'h40);
        cmp("R9", "bad sel link", int'(link_state), 2);

        // R7: transfer cycle
        bus_data_in = 8'hF5; tx_data = 5'h0A;
        pulse_xfer();
        step(4);
        cmp("R7", "rx latched", int'(rx_data), 'h15);
        cmp("R7", "cycle code", int'(irq_code), 'h1C);

        // R8: C/D dropped
        bus_cd_in = 1'b0;
        pulse_xfer();
        step(2);
        cmp("R8", "cd lost code", int'(irq_code), 'h1D);
        cmp("R8", "cd lost link", int'(link_state), 0);

        // R4: master loses to higher ID, retries
        bus_data_in = 8'h80; tmo_period = 8'd0;
        pulse_sel();
        step(4);
        pulse_xfer();
        step(6);
        cmp("R4", "master retrying", int'(link_state), 1);
        cmp("R9", "busy cmd code", int'(irq_code), 'h40);
        bus_data_in = 8'h08;
        step(8);
        cmp("R6", "no master code", int'(irq_code), 'h17);
        cmp("R6", "no master link", int'(link_state), 0);

        // R11 / R4: slave loses to any ID; role change ignored
        role_slave = 1'b1; bus_data_in = 8'h01; tmo_period = 8'd1; bus_cd_in = 1'b1;
        pulse_sel();
        step(8);
        cmp("R4", "slave retrying", int'(link_state), 1);
        role_slave = 1'b0;
        step(8);
        cmp("R11", "role captured", int'(link_state), 1);
        bus_sel_in = 1'b1;
        step(3);
        bus_sel_in = 1'b0; bus_data_in = 8'h00;
        step(12);
        cmp("R5", "slave linked", int'(link_state), 2);

        bus_data_in = 8'h0B; tx_data = 5'h13;
        pulse_xfer();
        step(4);
        cmp("R7", "second rx", int'(rx_data), 'h0B);
        step(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 5000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected<5000", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule